// File: doc/BRIEF.md
# Seconds Timer with Tick-Aligned Run Control

This block keeps elapsed seconds from a slow periodic tick (nominally 256 Hz) that is sampled in the system clock domain. Each falling edge of the tick advances a sub-second fraction counter while the timer is running. When that counter wraps, a two-digit BCD seconds value steps from 00 up to 59 and then back to 00. The wrap back to 00 raises a one-clock overflow pulse that a minute counter or interrupt source elsewhere can use.

Software controls the block through a small register port. Writing the control register only records a start or stop request. The timer's real run state changes at the next falling edge of the tick. Because of this, a stop still lets the timer count one more time, and the control bit keeps reading 1 until the halt has happened. Writing the seconds register loads a legal BCD value at once. The loaded value is not kept anywhere, so a later wrap always returns to 00.

Register map (address on `wr_addr_i` / `rd_addr_i`): 0 is the control register, with bit 0 as run; 1 is the seconds register, with the tens digit in bits 7:4 and the units digit in bits 3:0; 2 is the fraction count, which is read-only and zero-extended. Writes to addresses 2 and 3 have no effect, and address 3 reads as 0.

Top module: `clock_sec_timer`

## Requirements
- R1: After synchronous reset the timer is halted, and the seconds, fraction and control reads all return 0 with `ovf_o` low.
- R2: A write to control bit 0 changes the run state only at the next falling edge of `tick_i`. Until that edge, a read of address 0 returns the previous state in bit 0.
- R3: After a 0 is written while the timer is running, the fraction advances exactly once more at the next falling edge and then holds. The control read stays 1 until that edge.
- R4: While the timer is running, the fraction counter advances by one on each falling edge of `tick_i`. Rising edges, steady levels and a halted timer leave it unchanged.
- R5: When the fraction counter steps from TICKS_PER_SEC-1 to 0, the seconds value advances by one in BCD, so the units digit 9 rolls into the tens digit.
- R6: On the step from 59 the seconds value becomes 00, and `ovf_o` is high for exactly one clock in the cycle the 00 first reads back. It is never asserted otherwise.
- R7: A write to address 1 with a legal BCD value (tens digit 0 to 5, units digit 0 to 9) loads it in the next cycle. This load wins over an increment that falls in the same cycle.
- R8: A write to address 1 with a tens digit above 5 or a units digit above 9 leaves the seconds value unchanged.
- R9: When several control writes occur before a falling edge, only the last value written decides the run state applied at that edge.
- R10: After a preset, the wrap past 59 returns to 00 and never to the preset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow periodic tick level; its falling edges drive the timer |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 2 | Write address (0 control, 1 seconds) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address (0 control, 1 seconds, 2 fraction) |
| rd_data_o | output | 8 | Combinational read data for `rd_addr_i` |
| ovf_o | output | 1 | One-clock pulse on the 59 to 00 wrap |

## Verification
The bench builds the timer with TICKS_PER_SEC set to 4 and drives a tick period of eight clocks. With these values, a whole minute of seconds passes in under two thousand cycles. A natural 59 to 00 wrap, a wrap after a preset, and a full-minute count with exactly one overflow pulse can therefore all be observed. Because the fraction is short, the bench can also line up a seconds preset with the same clock as the tick edge that would increment it. It can likewise place stop and start writes a few clocks ahead of a known falling edge.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_SEC  = 2'd1,
        REG_FRAC = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RUN_HALTED = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd_sec_t;

    typedef struct packed {
        bcd_sec_t sec;
        logic     wrap;
    } sec_step_t;

    // Legal seconds value: tens 0..5, units 0..9
    function automatic logic bcd_sec_legal(input logic [7:0] v);
        return (v[7:4] <= 4'd5) && (v[3:0] <= 4'd9);
    endfunction

    // Next BCD second, flagging the wrap from 59 to 00
    function automatic sec_step_t bcd_sec_step(input bcd_sec_t s);
        sec_step_t r;
        r.sec  = s;
        r.wrap = 1'b0;
        if (s.units == 4'd9) begin
            r.sec.units = 4'd0;
            if (s.tens == 4'd5) begin
                r.sec.tens = 4'd0;
                r.wrap     = 1'b1;
            end else begin
                r.sec.tens = s.tens + 4'd1;
            end
        end else begin
            r.sec.units = s.units + 4'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/ctm_edge_det.sv
module ctm_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic fall_o
);
    logic tick_q;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= tick_i;
    end

    assign fall_o = tick_q & ~tick_i;
endmodule

// File: rtl/ctm_run_ctrl.sv
module ctm_run_ctrl
    import ctm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    input  logic wr_ctrl_i,
    input  logic wr_val_i,
    output logic run_o
);
    logic       req_q;
    logic       req_next;
    run_state_e state_q;

    // A write in the edge cycle is the latest request and is applied there
    assign req_next = wr_ctrl_i ? wr_val_i : req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            state_q <= RUN_HALTED;
        end else begin
            req_q <= req_next;
            if (fall_i) state_q <= req_next ? RUN_ACTIVE : RUN_HALTED;
        end
    end

    assign run_o = (state_q == RUN_ACTIVE);
endmodule

// File: rtl/ctm_sec_cnt.sv
module ctm_sec_cnt
    import ctm_pkg::*;
#(
    parameter int TICKS_PER_SEC = 256,
    parameter int FRAC_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic              run_i,
    input  logic              load_i,
    input  logic [7:0]        load_val_i,
    output logic [FRAC_W-1:0] frac_o,
    output bcd_sec_t          sec_o,
    output logic              ovf_o
);
    localparam logic [FRAC_W-1:0] FRAC_LAST = FRAC_W'(TICKS_PER_SEC - 1);

    logic [FRAC_W-1:0] frac_q;
    bcd_sec_t          sec_q;
    logic              ovf_q;
    logic              advance;
    logic              sec_tick;
    logic              load_ok;
    sec_step_t         step;

    assign advance  = fall_i & run_i;
    assign sec_tick = advance & (frac_q == FRAC_LAST);
    assign load_ok  = load_i & bcd_sec_legal(load_val_i);
    assign step     = bcd_sec_step(sec_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
            sec_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (advance) frac_q <= (frac_q == FRAC_LAST) ? '0 : frac_q + 1'b1;
            if (load_ok)       sec_q <= bcd_sec_t'(load_val_i);
            else if (sec_tick) sec_q <= step.sec;
            ovf_q <= sec_tick & step.wrap;
        end
    end

    assign frac_o = frac_q;
    assign sec_o  = sec_q;
    assign ovf_o  = ovf_q;
endmodule

// File: rtl/clock_sec_timer.sv
module clock_sec_timer
    import ctm_pkg::*;
#(
    parameter int TICKS_PER_SEC = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ovf_o
);
    localparam int FRAC_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

    logic              tick_fall;
    logic              run_act;
    logic [FRAC_W-1:0] frac_val;
    bcd_sec_t          sec_st;
    logic [7:0]        sec_val;
    logic              wr_ctrl;
    logic              wr_sec;

    assign wr_ctrl = wr_en_i & (reg_sel_e'(wr_addr_i) == REG_CTRL);
    assign wr_sec  = wr_en_i & (reg_sel_e'(wr_addr_i) == REG_SEC);
    assign sec_val = sec_st;

    ctm_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .fall_o (tick_fall)
    );

    ctm_run_ctrl u_run (
        .clk       (clk),
        .rst       (rst),
        .fall_i    (tick_fall),
        .wr_ctrl_i (wr_ctrl),
        .wr_val_i  (wr_data_i[0]),
        .run_o     (run_act)
    );

    ctm_sec_cnt #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .FRAC_W        (FRAC_W)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .fall_i     (tick_fall),
        .run_i      (run_act),
        .load_i     (wr_sec),
        .load_val_i (wr_data_i[7:0]),
        .frac_o     (frac_val),
        .sec_o      (sec_st),
        .ovf_o      (ovf_o)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_addr_i))
            REG_CTRL: rd_data_o = DATA_W'(run_act);
            REG_SEC:  rd_data_o = DATA_W'(sec_val);
            REG_FRAC: rd_data_o = DATA_W'(frac_val);
            default:  rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker
    import ctm_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic [7:0]        wr_data_i,
    input logic              tick_fall,
    input logic              run_act,
    input logic [7:0]        sec_val,
    input logic [FRAC_W-1:0] frac_val,
    input logic              ovf_o
);
    p_run_on_edge_only_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_fall |=> $stable(run_act));

    p_extra_count_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_fall && run_act) |=> (frac_val != $past(frac_val)));

    p_frac_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(tick_fall && run_act) |=> $stable(frac_val));

    p_sec_legal_r5: assert property (@(posedge clk) disable iff (rst)
        bcd_sec_legal(sec_val));

    p_ovf_from_59_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ($past(sec_val) == 8'h59));

    p_ovf_single_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> !ovf_o);

    p_legal_load_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == 2'd1 && bcd_sec_legal(wr_data_i))
        |=> (sec_val == $past(wr_data_i)));

    p_illegal_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == 2'd1 && !bcd_sec_legal(wr_data_i) && !(tick_fall && run_act))
        |=> $stable(sec_val));
endmodule

bind clock_sec_timer ctm_checker #(
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .tick_fall (tick_fall),
    .run_act   (run_act),
    .sec_val   (sec_val),
    .frac_val  (frac_val),
    .ovf_o     (ovf_o)
);

// File: tb/tb_clock_sec_timer.sv
module tb_clock_sec_timer;
    localparam int TPS = 4;
    localparam int TP  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       ovf;

    always #5 clk = ~clk;

    clock_sec_timer #(.TICKS_PER_SEC(TPS)) dut (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .ovf_o     (ovf)
    );

    int checks = 0;
    int errors = 0;
    int tcnt = 0;
    int ovf_cnt = 0;
    bit started = 1'b0;

    // behavioural reference state
    int m_tq, m_req, m_run, m_frac, m_sec, m_ovf;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int to_bcd(input int s);
        return (s / 10) * 16 + (s % 10);
    endfunction

    function automatic int m_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_run;
            2'd1:    return to_bcd(m_sec);
            2'd2:    return m_frac;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_tq = 0; m_req = 0; m_run = 0; m_frac = 0; m_sec = 0; m_ovf = 0;
        end else begin
            int req_n;
            int hi;
            int lo;
            bit fall;
            fall  = (m_tq == 1) && (tick == 1'b0);
            req_n = (wr_en && wr_addr == 2'd0) ? int'(wr_data[0]) : m_req;
            m_ovf = 0;
            if (fall) begin
                if (m_run == 1) begin
                    m_frac = m_frac + 1;
                    if (m_frac == TPS) begin
                        m_frac = 0;
                        m_sec  = m_sec + 1;
                        if (m_sec == 60) begin
                            m_sec = 0;
                            m_ovf = 1;
                        end
                    end
                end
                m_run = req_n;
            end
            hi = int'(wr_data[7:4]);
            lo = int'(wr_data[3:0]);
            if (wr_en && wr_addr == 2'd1 && hi <= 5 && lo <= 9) m_sec = hi * 10 + lo;
            m_req = req_n;
            m_tq  = int'(tick);
        end
    end

    // compare every cycle, then advance the tick waveform
    always @(negedge clk) begin
        if (!rst && started) begin
            case (rd_addr)
                2'd0:    check("R2 control readback", rd_data, m_read(rd_addr));
                2'd1:    check("R5 seconds value", rd_data, m_read(rd_addr));
                2'd2:    check("R4 fraction value", rd_data, m_read(rd_addr));
                default: check("R2 unused address", rd_data, m_read(rd_addr));
            endcase
            check("R6 overflow pulse", ovf, m_ovf);
            if (ovf) ovf_cnt++;
        end
        #1;
        if (rst) begin
            tcnt = 0;
            tick = 1'b0;
        end else begin
            tcnt++;
            tick = (tcnt % TP) < (TP / 2);
        end
    end

    task automatic slot();
        @(negedge clk);
        #2;
    endtask

    task automatic wait_phase(input int p);
        do slot(); while ((tcnt % TP) != p);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        slot();
        wr_en   = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] f0;
        int n;
        int base;
        repeat (4) slot();
        rst = 1'b0;
        started = 1'b1;
        slot();

        // R1 reset state
        peek(2'd0, v); check("R1 control after reset", v, 8'h00);
        peek(2'd1, v); check("R1 seconds after reset", v, 8'h00);
        peek(2'd2, v); check("R1 fraction after reset", v, 8'h00);
        check("R1 overflow after reset", ovf, 1'b0);

        // R2 start waits for falling edge
        wait_phase(0);
        wr(2'd0, 8'h01);
        peek(2'd0, v); check("R2 still halted before edge", v, 8'h00);
        peek(2'd2, v); check("R2 no count before edge", v, 8'h00);
        wait_phase(5);
        peek(2'd0, v); check("R2 running after edge", v, 8'h01);

        // R4 one count per falling edge, rising edge no effect
        peek(2'd2, f0);
        wait_phase(3);
        peek(2'd2, v); check("R4 rising edge no count", v, f0);
        wait_phase(5);
        peek(2'd2, v); check("R4 one count per edge", v, 8'((f0 + 1) % TPS));

        // R5 seconds step after TPS edges
        repeat (2 * TPS) wait_phase(5);

        // R7 legal preset
        wait_phase(0);
        wr(2'd1, 8'h58);
        peek(2'd1, v); check("R7 preset loaded", v, 8'h58);

        // R8 illegal presets ignored
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'h60);
        peek(2'd1, v); check("R8 illegal preset ignored", v, 8'h58);

        // R6 / R10 wrap after preset returns to 00
        base = ovf_cnt;
        n = (TPS - m_frac) + TPS;
        repeat (n) wait_phase(5);
        peek(2'd1, v); check("R10 wrap returns to zero", v, 8'h00);
        check("R6 one overflow pulse", ovf_cnt - base, 1);

        // R7 preset wins over coincident increment
        do wait_phase(4); while (m_frac != TPS - 1);
        wr(2'd1, 8'h30);
        peek(2'd1, v); check("R7 load beats increment", v, 8'h30);
        peek(2'd2, v); check("R7 fraction still wraps", v, 8'h00);

        // R6 full minute gives exactly one overflow
        base = ovf_cnt;
        repeat (60 * TPS) wait_phase(5);
        check("R6 one overflow per minute", ovf_cnt - base, 1);

        // R3 stop costs one extra count
        wait_phase(0);
        peek(2'd2, f0);
        wr(2'd0, 8'h00);
        peek(2'd0, v); check("R3 reads 1 until halt", v, 8'h01);
        wait_phase(5);
        peek(2'd0, v); check("R3 halted after edge", v, 8'h00);
        peek(2'd2, v); check("R3 one extra count", v, 8'((f0 + 1) % TPS));
        wait_phase(5);
        peek(2'd2, v); check("R3 holds after halt", v, 8'((f0 + 1) % TPS));

        // R9 last written value wins
        wait_phase(0);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h00);
        wait_phase(5);
        peek(2'd0, v); check("R9 last write 0 keeps halted", v, 8'h00);
        wait_phase(0);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h01);
        wait_phase(5);
        peek(2'd0, v); check("R9 last write 1 starts", v, 8'h01);
        repeat (3) wait_phase(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule